// File: doc/BRIEF.md
# VLAN Violation Capture Unit

This block sits beside a switch forwarding path and watches the result of every VLAN lookup. Each lookup result carries a 13-bit VLAN ID, a 4-bit source port number and two flags. The miss flag means the VLAN ID was not found in the table. The member flag means the source port does not belong to that VLAN. When either flag is set, the block stores the violation in a capture record and drives a level interrupt to the host.

Software reads and clears the record with one command. It writes the get-and-clear opcode with the busy bit set. It then polls until busy drops. The operation register then shows which kinds of violation were captured, an overflow indication and the source port. The VID register shows the offending VLAN ID. The same completion clears the record and drops the interrupt, so one access both reports and rearms.

Only the first violation is kept while one is pending. Later violations only set a sticky overflow bit. The table lookup itself is not part of this block.

Top module: `vlan_viol_capture`

## Requirements
- R1: After reset, `irq` is 0, `opRdData` reads 0x0000 and `vidRdData` reads 0x0000.
- R2: A lookup with `lkValid`=1 and at least one of `lkMiss`/`lkMember` set raises `irq` one clock later. `irq` is a level and stays high until a get-and-clear completes.
- R3: A write with `opWrEn`=1 is an accepted command when bit 15 (busy) is 1, bits 14:12 hold opcode 3'b111 and no command is running. After an accepted command, `opRdData[15]` reads 1 for exactly CMD_LAT clock cycles and then reads 0.
- R4: After completion, the operation register reads as follows: bits 14:12 hold the opcode, bits 3:0 hold the captured source port, bit 6 is the member-violation flag and bit 5 is the miss-violation flag. These fields do not change while busy is 1.
- R5: After completion, `vidRdData[11:0]` holds the low 12 bits of the captured VID and `vidRdData[13]` holds VID bit 12 (the page bit). All other bits read 0.
- R6: While a violation is pending, later violations do not overwrite the port, VID or flags. They set the sticky overflow flag, which reads in operation register bit 7.
- R7: Completion of get-and-clear drops `irq` and clears the record. A get-and-clear with nothing pending reports flags, overflow, port and VID all as 0.
- R8: A lookup with both `lkMiss` and `lkMember` set gives one record with both bit 5 and bit 6 set.
- R9: Writes with bit 15 clear or with an opcode other than 3'b111 are ignored. A write while busy is 1 is also ignored and does not lengthen the command.
- R10: Lookups with `lkValid`=0, or with `lkValid`=1 and both flags clear, capture nothing and leave `irq` low.
- R11: A violation in the completion cycle (the last busy cycle) is dropped. Capture is armed again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup result valid |
| lkVid | input | 13 | VLAN ID of the looked-up frame (bit 12 is the page bit) |
| lkPort | input | 4 | Source port of the frame |
| lkMiss | input | 1 | VLAN ID not present in the table |
| lkMember | input | 1 | Source port is not a member of the VLAN |
| opWrEn | input | 1 | Write strobe for the operation register |
| opWrData | input | 16 | Operation register write data |
| opRdData | output | 16 | Operation register read value |
| vidRdData | output | 16 | VID register read value |
| irq | output | 1 | Level interrupt, high while a violation is pending |

## Verification
The hardest case to reach is a violation that arrives in exactly the last busy cycle of a get-and-clear. That violation must be dropped, while one that arrives a single cycle later must be captured. The bench issues the command and counts CMD_LAT-1 falling edges after the write. It presents one violation there and a different one on the next cycle. It then checks that `irq` stays low after the first violation and rises after the second, and a further get-and-clear shows that the second violation's port was the one kept. The overflow path needs two violations to land before any command. The bench also issues a command write while a command is already busy, to show that the busy window does not stretch.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
  localparam int PORT_W = 4;
  localparam int VID_W = 13;
  localparam int REG_W = 16;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_GET_CLEAR = 3'b111;
  localparam int BUSY_POS = 15;
  localparam int OPC_LSB = 12;
  localparam int OVF_POS = 7;
  localparam int MEMBER_POS = 6;
  localparam int MISS_POS = 5;
  localparam int PAGE_POS = 13;

  typedef struct packed {
    logic busy;
    logic complete;
  } vvc_strobe_t;
endpackage

// File: rtl/vvc_ctrl.sv
module vvc_ctrl
  import vvc_pkg::*;
#(
  parameter int CMD_LAT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 opWrEn,
  input  logic [REG_W-1:0]     opWrData,
  output vvc_strobe_t          strb,
  output logic [OPC_W-1:0]     opCode
);
  localparam int CNT_W = $clog2(CMD_LAT + 1);

  logic busyQ;
  logic [CNT_W-1:0] cntQ;
  logic startCmd;

  assign startCmd = opWrEn && opWrData[BUSY_POS]
                 && (opWrData[OPC_LSB +: OPC_W] == OPC_GET_CLEAR) && !busyQ;

  assign strb.busy = busyQ;
  assign strb.complete = busyQ && (cntQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      cntQ <= '0;
      opCode <= '0;
    end else if (startCmd) begin
      busyQ <= 1'b1;
      cntQ <= CNT_W'(CMD_LAT);
      opCode <= opWrData[OPC_LSB +: OPC_W];
    end else if (busyQ) begin
      if (strb.complete) begin
        busyQ <= 1'b0;
        cntQ <= '0;
      end else begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vvc_datapath.sv
module vvc_datapath
  import vvc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  vvc_strobe_t        strb,
  input  logic               lkValid,
  input  logic [VID_W-1:0]   lkVid,
  input  logic [PORT_W-1:0]  lkPort,
  input  logic               lkMiss,
  input  logic               lkMember,
  output logic               capValid,
  output logic [VID_W-1:0]   capVid,
  output logic [PORT_W-1:0]  capPort,
  output logic               resMember,
  output logic               resMiss,
  output logic               resOvf,
  output logic [PORT_W-1:0]  resPort,
  output logic [VID_W-1:0]   resVid
);
  logic capMember, capMiss, capOvf;
  logic isViol;

  assign isViol = lkValid && (lkMiss || lkMember);

  always_ff @(posedge clk) begin
    if (!rst_n || strb.complete) begin
      capValid <= 1'b0;
      capMember <= 1'b0;
      capMiss <= 1'b0;
      capOvf <= 1'b0;
      capPort <= '0;
      capVid <= '0;
    end else if (isViol) begin
      if (!capValid) begin
        capValid <= 1'b1;
        capMember <= lkMember;
        capMiss <= lkMiss;
        capPort <= lkPort;
        capVid <= lkVid;
      end else begin
        capOvf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resMember <= 1'b0;
      resMiss <= 1'b0;
      resOvf <= 1'b0;
      resPort <= '0;
      resVid <= '0;
    end else if (strb.complete) begin
      resMember <= capMember;
      resMiss <= capMiss;
      resOvf <= capOvf;
      resPort <= capPort;
      resVid <= capVid;
    end
  end
endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
  import vvc_pkg::*;
#(
  parameter int CMD_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lkValid,
  input  logic [VID_W-1:0]   lkVid,
  input  logic [PORT_W-1:0]  lkPort,
  input  logic               lkMiss,
  input  logic               lkMember,
  input  logic               opWrEn,
  input  logic [REG_W-1:0]   opWrData,
  output logic [REG_W-1:0]   opRdData,
  output logic [REG_W-1:0]   vidRdData,
  output logic               irq
);
  vvc_strobe_t strb;
  logic [OPC_W-1:0] opCode;
  logic capValid;
  logic [VID_W-1:0] capVid;
  logic [PORT_W-1:0] capPort;
  logic resMember, resMiss, resOvf;
  logic [PORT_W-1:0] resPort;
  logic [VID_W-1:0] resVid;

  vvc_ctrl #(.CMD_LAT(CMD_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .opWrEn(opWrEn), .opWrData(opWrData),
    .strb(strb), .opCode(opCode)
  );

  vvc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .lkValid(lkValid), .lkVid(lkVid), .lkPort(lkPort),
    .lkMiss(lkMiss), .lkMember(lkMember),
    .capValid(capValid), .capVid(capVid), .capPort(capPort),
    .resMember(resMember), .resMiss(resMiss), .resOvf(resOvf),
    .resPort(resPort), .resVid(resVid)
  );

  always_comb begin
    opRdData = '0;
    opRdData[BUSY_POS] = strb.busy;
    opRdData[OPC_LSB +: OPC_W] = opCode;
    opRdData[OVF_POS] = resOvf;
    opRdData[MEMBER_POS] = resMember;
    opRdData[MISS_POS] = resMiss;
    opRdData[PORT_W-1:0] = resPort;
    vidRdData = '0;
    vidRdData[11:0] = resVid[11:0];
    vidRdData[PAGE_POS] = resVid[12];
  end

  assign irq = capValid;
endmodule

// File: rtl/vvc_chk.sv
module vvc_chk
  import vvc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               lkValid,
  input logic               lkMiss,
  input logic               lkMember,
  input logic               opWrEn,
  input logic [REG_W-1:0]   opWrData,
  input logic [REG_W-1:0]   opRdData,
  input vvc_strobe_t        strb,
  input logic               capValid,
  input logic [VID_W-1:0]   capVid,
  input logic [PORT_W-1:0]  capPort
);
  AST_VIOL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && (lkMiss || lkMember) && !strb.complete) |=> irq); // R2
  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (opWrEn && opWrData[BUSY_POS] && opWrData[OPC_LSB +: OPC_W] == OPC_GET_CLEAR
     && !opRdData[BUSY_POS]) |=> opRdData[BUSY_POS]); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (opRdData[BUSY_POS] && $past(opRdData[BUSY_POS])) |-> $stable(opRdData[7:0])); // R4
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (capValid && $past(capValid)) |-> ($stable(capVid) && $stable(capPort))); // R6
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(opRdData[BUSY_POS]) |-> !irq); // R7
  AST_COMPLETE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.complete |=> !irq); // R11
endmodule

bind vlan_viol_capture vvc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .lkValid(lkValid), .lkMiss(lkMiss),
  .lkMember(lkMember), .opWrEn(opWrEn), .opWrData(opWrData), .opRdData(opRdData),
  .strb(strb), .capValid(capValid), .capVid(capVid), .capPort(capPort)
);

// File: tb/sim_vlan_viol_capture.sv
`timescale 1ns/1ps
module sim_vlan_viol_capture;
  localparam int CMD_LAT = 4;
  localparam logic [15:0] GC = 16'hF000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkValid = 1'b0;
  logic [12:0] lkVid = '0;
  logic [3:0] lkPort = '0;
  logic lkMiss = 1'b0;
  logic lkMember = 1'b0;
  logic opWrEn = 1'b0;
  logic [15:0] opWrData = '0;
  logic [15:0] opRdData, vidRdData;
  logic irq;
  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  vlan_viol_capture #(.CMD_LAT(CMD_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .lkVid(lkVid), .lkPort(lkPort),
    .lkMiss(lkMiss), .lkMember(lkMember), .opWrEn(opWrEn), .opWrData(opWrData),
    .opRdData(opRdData), .vidRdData(vidRdData), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic v, input logic [12:0] vid, input logic [3:0] p,
                        input logic miss, input logic mem);
    @(negedge clk);
    lkValid = v; lkVid = vid; lkPort = p; lkMiss = miss; lkMember = mem;
    @(negedge clk);
    lkValid = 1'b0; lkMiss = 1'b0; lkMember = 1'b0;
  endtask

  task automatic getClear(input string req);
    int cnt = 0;
    @(negedge clk);
    opWrEn = 1'b1; opWrData = GC;
    @(negedge clk);
    opWrEn = 1'b0;
    while (opRdData[15] && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check({req, " busy length R3"}, 16'(cnt), 16'(CMD_LAT));
  endtask

  task automatic tReset();
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 op", opRdData, 16'h0);
    check("R1 vid", vidRdData, 16'h0);
  endtask

  task automatic tMember();
    lookup(1'b1, 13'h0123, 4'd5, 1'b0, 1'b1);
    check("R2 irq raised", {15'b0, irq}, 16'h1);
    repeat (3) @(negedge clk);
    check("R2 irq level", {15'b0, irq}, 16'h1);
    getClear("R4");
    check("R4 member+port", opRdData, 16'h7045);
    check("R5 vid", vidRdData, 16'h0123);
    check("R7 irq cleared", {15'b0, irq}, 16'h0);
  endtask

  task automatic tMissPage();
    lookup(1'b1, 13'h1ABC, 4'hF, 1'b1, 1'b0);
    getClear("R5");
    check("R4 miss+port", opRdData, 16'h702F);
    check("R5 page vid", vidRdData, 16'h2ABC);
  endtask

  task automatic tBoth();
    lookup(1'b1, 13'h0007, 4'd2, 1'b1, 1'b1);
    getClear("R8");
    check("R8 both flags", opRdData, 16'h7062);
  endtask

  task automatic tOverflow();
    lookup(1'b1, 13'h0010, 4'd3, 1'b1, 1'b0);
    lookup(1'b1, 13'h0020, 4'd9, 1'b0, 1'b1);
    getClear("R6");
    check("R6 first kept + ovf", opRdData, 16'h70A3);
    check("R6 vid kept", vidRdData, 16'h0010);
    getClear("R7");
    check("R7 empty op", opRdData, 16'h7000);
    check("R7 empty vid", vidRdData, 16'h0000);
  endtask

  task automatic tNonViol();
    lookup(1'b1, 13'h0055, 4'd1, 1'b0, 1'b0);
    lookup(1'b0, 13'h0056, 4'd4, 1'b1, 1'b1);
    check("R10 no irq", {15'b0, irq}, 16'h0);
    getClear("R10");
    check("R10 nothing captured", opRdData, 16'h7000);
  endtask

  task automatic tIgnored();
    int cnt = 0;
    @(negedge clk); opWrEn = 1'b1; opWrData = 16'h7000;
    @(negedge clk); opWrEn = 1'b0;
    check("R9 busy bit clear", {15'b0, opRdData[15]}, 16'h0);
    @(negedge clk); opWrEn = 1'b1; opWrData = 16'hB000;
    @(negedge clk); opWrEn = 1'b0;
    check("R9 wrong opcode", opRdData, 16'h7000);
    @(negedge clk); opWrEn = 1'b1; opWrData = GC;
    @(negedge clk); opWrEn = 1'b0;
    cnt = 1;
    @(negedge clk); opWrEn = 1'b1; opWrData = GC;
    cnt++;
    @(negedge clk); opWrEn = 1'b0;
    while (opRdData[15] && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check("R9 write while busy", 16'(cnt), 16'(CMD_LAT));
  endtask

  task automatic tDrop();
    @(negedge clk); opWrEn = 1'b1; opWrData = GC;
    @(negedge clk); opWrEn = 1'b0;
    repeat (CMD_LAT - 1) @(negedge clk);
    lkValid = 1'b1; lkVid = 13'h0AAA; lkPort = 4'd6; lkMember = 1'b1; lkMiss = 1'b0;
    @(negedge clk);
    check("R11 dropped in completion cycle", {15'b0, irq}, 16'h0);
    lkVid = 13'h0BBB; lkPort = 4'd7; lkMember = 1'b0; lkMiss = 1'b1;
    @(negedge clk);
    lkValid = 1'b0; lkMiss = 1'b0;
    check("R11 rearmed", {15'b0, irq}, 16'h1);
    getClear("R11");
    check("R11 second kept", opRdData, 16'h7027);
    check("R11 second vid", vidRdData, 16'h0BBB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tMember();
    tMissPage();
    tBoth();
    tOverflow();
    tNonViol();
    tIgnored();
    tDrop();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule